// File: doc/BRIEF.md
# Circular FIFO with Peek, Poke and Blocking Requests

A synchronous first-in first-out store kept as a ring of `DEPTH` entries, with a write index, a read index and an occupancy count. It takes at most one command per cycle. The commands are blocking and non-blocking forms of put, get and peek, plus a poke. Every command that is taken gets a registered response one cycle later, with a success flag and read data.

A blocking request that cannot complete does not answer at once. It becomes pending and raises `busy_o`. While it is pending, only the opposing operation is taken. When the request becomes legal it completes on its own, one cycle after the legal state is reached.

Peek reads the oldest entry and leaves it in place. Poke writes at the write index without advancing it. On a full store the write index equals the read index, so a poke replaces the oldest unread entry. The fill state and three capability flags are combinational, derived from the occupancy count.

Top module: `circ_fifo_pp`

## Requirements
- R1: After the active-low reset `rst_ni`: `level_o` is 0, `state_o` is empty, `busy_o` is 0 and `resp_valid_o` is 0.
- R2: Commands use these `cmd_op_i` codes: 0 blocking put, 1 non-blocking put, 2 blocking get, 3 non-blocking get, 4 blocking peek, 5 non-blocking peek, 6 poke, 7 no operation.
  - A taken command answers on `resp_valid_o`/`resp_ok_o`/`resp_data_o` in the cycle after the edge that takes it.
  - A put stores at the write index, advances it modulo `DEPTH` and increments `level_o`.
  - A get returns the entry at the read index, advances it modulo `DEPTH` and decrements `level_o`.
  - Data leaves in arrival order, including across index wraparound.
- R3: `state_o` is 0 when `level_o` is 0, 2 when `level_o` equals `DEPTH`, and 1 otherwise. `can_put_o` is high exactly when `level_o` < `DEPTH`. `can_get_o` and `can_peek_o` are high exactly when `level_o` > 0. All of these are combinational.
- R4: A non-blocking put on a full store answers with `resp_ok_o`=0, stores nothing and leaves `level_o` at `DEPTH`.
- R5: A non-blocking get or a non-blocking peek on an empty store answers with `resp_ok_o`=0 and leaves `level_o` at 0.
- R6: A peek returns the oldest entry with `resp_ok_o`=1 and changes neither `level_o` nor the order of later gets.
- R7: A poke on a non-empty store answers `resp_ok_o`=1 and writes at the write index without advancing it. It never changes `level_o`. On a full store it replaces the oldest entry. On an empty store it is ignored and answers `resp_ok_o`=0.
- R8: A blocking put on a full store gives no response and raises `busy_o`. After a get is taken, the put completes in the following cycle: it answers with `resp_ok_o`=1, drops `busy_o`, and its data is last in order.
- R9: A blocking get or peek on an empty store gives no response and raises `busy_o`. After a put is taken, the pending request completes in the following cycle and returns that put's data. A pending get consumes the data; a pending peek leaves it stored.
- R10: While `busy_o` is high, any command that is not of the opposing kind is ignored: no response and no state change. Code 7 is never answered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Command code (see R2) |
| cmd_data_i | input | WIDTH | Data for put and poke |
| resp_valid_o | output | 1 | Response present |
| resp_ok_o | output | 1 | Success flag of the response |
| resp_data_o | output | WIDTH | Data returned by get or peek |
| busy_o | output | 1 | A blocking request is pending |
| level_o | output | $clog2(DEPTH+1) | Number of stored entries |
| state_o | output | 2 | 0 empty, 1 semi-full, 2 full |
| can_put_o | output | 1 | A put would succeed now |
| can_get_o | output | 1 | A get would succeed now |
| can_peek_o | output | 1 | A peek would succeed now |

## Verification
Direct command responses, `level_o` and `busy_o` are due one edge after the command is taken. The bench drives on a falling edge and samples at the next falling edge, which falls after exactly one rising edge.

A pending request finishes one edge later again. After the opposing command, the bench waits one more falling edge with no command before it checks the completion. The combinational flags are sampled in the same half-cycle as `level_o`.

// File: rtl/fifo_pp_pkg.sv
package fifo_pp_pkg;
  typedef enum logic [2:0] {
    OP_PUT_B   = 3'd0,
    OP_PUT_NB  = 3'd1,
    OP_GET_B   = 3'd2,
    OP_GET_NB  = 3'd3,
    OP_PEEK_B  = 3'd4,
    OP_PEEK_NB = 3'd5,
    OP_POKE    = 3'd6,
    OP_NOP     = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_SEMI  = 2'd1,
    ST_FULL  = 2'd2
  } fill_e;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_PUT  = 2'd1,
    PK_GET  = 2'd2,
    PK_PEEK = 2'd3
  } pend_e;
endpackage

// File: rtl/fifo_pp_store.sv
module fifo_pp_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             poke_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] front_o,
  output logic [LW-1:0]    level_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wi_q, ri_q;
  logic [LW-1:0]    used_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if ((push_i || poke_i) && wi_q == PW'(e)) mem_q[e] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wi_q   <= '0;
      ri_q   <= '0;
      used_q <= '0;
    end else begin
      if (push_i) wi_q <= step(wi_q);
      if (pop_i)  ri_q <= step(ri_q);
      if (push_i && !pop_i)      used_q <= used_q + LW'(1);
      else if (pop_i && !push_i) used_q <= used_q - LW'(1);
    end
  end

  assign front_o = mem_q[ri_q];
  assign level_o = used_q;
endmodule

// File: rtl/fifo_pp_ctrl.sv
module fifo_pp_ctrl
  import fifo_pp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  op_e              cmd_op_i,
  input  logic [WIDTH-1:0] cmd_data_i,
  input  logic             full_i,
  input  logic             empty_i,
  input  logic [WIDTH-1:0] front_i,
  output logic             push_o,
  output logic             pop_o,
  output logic             poke_o,
  output logic [WIDTH-1:0] wdata_o,
  output logic             resp_valid_o,
  output logic             resp_ok_o,
  output logic [WIDTH-1:0] resp_data_o,
  output logic             busy_o
);
  pend_e            pk_q, pk_d;
  logic [WIDTH-1:0] pdata_q, pdata_d;
  logic             rv_d, ok_d, take, pend_ready, opposing;
  logic [WIDTH-1:0] rd_d;

  always_comb begin
    push_o = 1'b0; pop_o = 1'b0; poke_o = 1'b0; wdata_o = cmd_data_i;
    rv_d = 1'b0; ok_d = 1'b0; rd_d = '0;
    pk_d = pk_q; pdata_d = pdata_q; take = 1'b0;
    pend_ready = (pk_q == PK_PUT) ? !full_i : (pk_q != PK_NONE) && !empty_i;
    opposing   = (pk_q == PK_PUT) ? (cmd_op_i == OP_GET_B || cmd_op_i == OP_GET_NB)
                                  : (cmd_op_i == OP_PUT_B || cmd_op_i == OP_PUT_NB);
    if (pk_q != PK_NONE) begin
      if (pend_ready) begin
        rv_d = 1'b1; ok_d = 1'b1; pk_d = PK_NONE;
        case (pk_q)
          PK_PUT:  begin push_o = 1'b1; wdata_o = pdata_q; end
          PK_GET:  begin pop_o = 1'b1; rd_d = front_i; end
          default: rd_d = front_i;
        endcase
      end else begin
        take = cmd_valid_i && opposing;
      end
    end else begin
      take = cmd_valid_i;
    end

    if (take) begin
      case (cmd_op_i)
        OP_PUT_B, OP_PUT_NB: begin
          if (!full_i) begin
            push_o = 1'b1; rv_d = 1'b1; ok_d = 1'b1;
          end else if (cmd_op_i == OP_PUT_B) begin
            pk_d = PK_PUT; pdata_d = cmd_data_i;
          end else begin
            rv_d = 1'b1;
          end
        end
        OP_GET_B, OP_GET_NB, OP_PEEK_B, OP_PEEK_NB: begin
          if (!empty_i) begin
            pop_o = (cmd_op_i == OP_GET_B || cmd_op_i == OP_GET_NB);
            rv_d = 1'b1; ok_d = 1'b1; rd_d = front_i;
          end else if (cmd_op_i == OP_GET_B) begin
            pk_d = PK_GET;
          end else if (cmd_op_i == OP_PEEK_B) begin
            pk_d = PK_PEEK;
          end else begin
            rv_d = 1'b1;
          end
        end
        OP_POKE: begin
          rv_d = 1'b1;
          if (!empty_i) begin
            poke_o = 1'b1; ok_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pk_q         <= PK_NONE;
      pdata_q      <= '0;
      resp_valid_o <= 1'b0;
      resp_ok_o    <= 1'b0;
      resp_data_o  <= '0;
    end else begin
      pk_q         <= pk_d;
      pdata_q      <= pdata_d;
      resp_valid_o <= rv_d;
      resp_ok_o    <= ok_d;
      resp_data_o  <= rd_d;
    end
  end

  assign busy_o = (pk_q != PK_NONE);
endmodule

// File: rtl/circ_fifo_pp.sv
module circ_fifo_pp
  import fifo_pp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [WIDTH-1:0] cmd_data_i,
  output logic             resp_valid_o,
  output logic             resp_ok_o,
  output logic [WIDTH-1:0] resp_data_o,
  output logic             busy_o,
  output logic [LW-1:0]    level_o,
  output logic [1:0]       state_o,
  output logic             can_put_o,
  output logic             can_get_o,
  output logic             can_peek_o
);
  logic             push, pop, poke, full, empty;
  logic [WIDTH-1:0] wdata, front;

  fifo_pp_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .poke_i  (poke),
    .wdata_i (wdata),
    .front_o (front),
    .level_o (level_o)
  );

  assign full  = (level_o == LW'(DEPTH));
  assign empty = (level_o == '0);

  fifo_pp_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (op_e'(cmd_op_i)),
    .cmd_data_i   (cmd_data_i),
    .full_i       (full),
    .empty_i      (empty),
    .front_i      (front),
    .push_o       (push),
    .pop_o        (pop),
    .poke_o       (poke),
    .wdata_o      (wdata),
    .resp_valid_o (resp_valid_o),
    .resp_ok_o    (resp_ok_o),
    .resp_data_o  (resp_data_o),
    .busy_o       (busy_o)
  );

  always_comb begin
    if (empty)     state_o = ST_EMPTY;
    else if (full) state_o = ST_FULL;
    else           state_o = ST_SEMI;
  end

  assign can_put_o  = !full;
  assign can_get_o  = !empty;
  assign can_peek_o = !empty;
endmodule

// File: rtl/fifo_pp_chk.sv
module fifo_pp_chk #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [2:0]    cmd_op_i,
  input logic          resp_valid_o,
  input logic          resp_ok_o,
  input logic          busy_o,
  input logic [LW-1:0] level_o,
  input logic [1:0]    state_o
);
  logic idle_cmd;
  assign idle_cmd = cmd_valid_i && !busy_o;

  assert_level_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH));

  assert_state_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(state_o));

  assert_nb_put_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_cmd && cmd_op_i == 3'd1 && level_o == LW'(DEPTH))
      |=> (resp_valid_o && !resp_ok_o && level_o == LW'(DEPTH)));

  assert_nb_get_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_cmd && (cmd_op_i == 3'd3 || cmd_op_i == 3'd5) && level_o == '0)
      |=> (resp_valid_o && !resp_ok_o && level_o == '0));

  assert_peek_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_cmd && cmd_op_i == 3'd5 && level_o != '0)
      |=> (resp_valid_o && resp_ok_o && $stable(level_o)));

  assert_poke_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_cmd && cmd_op_i == 3'd6) |=> $stable(level_o));

  assert_block_put_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_cmd && cmd_op_i == 3'd0 && level_o == LW'(DEPTH))
      |=> (busy_o && !resp_valid_o));

  assert_nop_silent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_cmd && cmd_op_i == 3'd7) |=> (!resp_valid_o && $stable(level_o)));
endmodule

bind circ_fifo_pp fifo_pp_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_op_i     (cmd_op_i),
  .resp_valid_o (resp_valid_o),
  .resp_ok_o    (resp_ok_o),
  .busy_o       (busy_o),
  .level_o      (level_o),
  .state_o      (state_o)
);

// File: tb/tb_circ_fifo_pp.sv
module tb_circ_fifo_pp;
  localparam int DEPTH = 4;
  localparam int WIDTH = 16;
  localparam int LW = $clog2(DEPTH + 1);
  localparam time TCK = 5ns;

  localparam logic [2:0] PUT_B = 3'd0, PUT_NB = 3'd1, GET_B = 3'd2, GET_NB = 3'd3,
                         PEEK_B = 3'd4, PEEK_NB = 3'd5, POKE = 3'd6, NOP = 3'd7;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [2:0] cmd_op_i = '0;
  logic [WIDTH-1:0] cmd_data_i = '0;
  logic resp_valid_o, resp_ok_o, busy_o, can_put_o, can_get_o, can_peek_o;
  logic [WIDTH-1:0] resp_data_o;
  logic [LW-1:0] level_o;
  logic [1:0] state_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(TCK / 2) clk = ~clk;

  circ_fifo_pp #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_data_i(cmd_data_i), .resp_valid_o(resp_valid_o), .resp_ok_o(resp_ok_o),
    .resp_data_o(resp_data_o), .busy_o(busy_o), .level_o(level_o), .state_o(state_o),
    .can_put_o(can_put_o), .can_get_o(can_get_o), .can_peek_o(can_peek_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive on a falling edge, return at the next falling edge (one rising edge later)
  task automatic issue(logic [2:0] op, logic [WIDTH-1:0] d);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_data_i = d;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic resp_is(string req, int v, int ok, int d);
    chk(req, "resp_valid", resp_valid_o, v);
    chk(req, "resp_ok", resp_ok_o, ok);
    if (v == 1 && ok == 1) chk(req, "resp_data", resp_data_o, d);
  endtask

  task automatic flags_are(string req, int lvl);
    chk(req, "level", level_o, lvl);
    chk(req, "state", state_o, lvl == 0 ? 0 : (lvl == DEPTH ? 2 : 1));
    chk(req, "can_put", can_put_o, lvl < DEPTH);
    chk(req, "can_get", can_get_o, lvl > 0);
    chk(req, "can_peek", can_peek_o, lvl > 0);
  endtask

  task automatic t_reset;
    chk("R1", "level", level_o, 0);
    chk("R1", "state", state_o, 0);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "resp_valid", resp_valid_o, 0);
  endtask

  task automatic t_order_wrap;
    for (int i = 0; i < 3; i++) begin
      issue(PUT_B, 16'hA0 + 16'(i)); resp_is("R2", 1, 1, 0); flags_are("R3", i + 1);
    end
    for (int i = 0; i < 2; i++) begin
      issue(GET_B, 16'h0); resp_is("R2", 1, 1, 16'hA0 + i);
    end
    flags_are("R3", 1);
    for (int i = 3; i < 6; i++) begin
      issue(PUT_NB, 16'hA0 + 16'(i)); resp_is("R2", 1, 1, 0);
    end
    flags_are("R3", 4);
    for (int i = 2; i < 6; i++) begin
      issue(GET_NB, 16'h0); resp_is("R2", 1, 1, 16'hA0 + i);
    end
    flags_are("R3", 0);
  endtask

  task automatic t_limits;
    issue(GET_NB, 16'h0);  resp_is("R5", 1, 0, 0); flags_are("R5", 0);
    issue(PEEK_NB, 16'h0); resp_is("R5", 1, 0, 0); flags_are("R5", 0);
    for (int i = 0; i < DEPTH; i++) issue(PUT_NB, 16'hB0 + 16'(i));
    issue(PUT_NB, 16'hBF); resp_is("R4", 1, 0, 0); flags_are("R4", DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      issue(GET_NB, 16'h0); resp_is("R4", 1, 1, 16'hB0 + i);
    end
    flags_are("R4", 0);
  endtask

  task automatic t_peek;
    issue(PUT_B, 16'hC1); issue(PUT_B, 16'hC2);
    issue(PEEK_NB, 16'h0); resp_is("R6", 1, 1, 16'hC1); flags_are("R6", 2);
    issue(PEEK_B, 16'h0);  resp_is("R6", 1, 1, 16'hC1); flags_are("R6", 2);
    issue(GET_B, 16'h0); resp_is("R6", 1, 1, 16'hC1);
    issue(GET_B, 16'h0); resp_is("R6", 1, 1, 16'hC2);
  endtask

  task automatic t_poke;
    issue(POKE, 16'hD0); resp_is("R7", 1, 0, 0); flags_are("R7", 0);
    issue(PUT_B, 16'hD1);
    issue(POKE, 16'hDE); resp_is("R7", 1, 1, 0); flags_are("R7", 1);
    issue(PEEK_NB, 16'h0); resp_is("R7", 1, 1, 16'hD1);
    issue(GET_B, 16'h0);   resp_is("R7", 1, 1, 16'hD1);
    for (int i = 0; i < DEPTH; i++) issue(PUT_B, 16'hE0 + 16'(i));
    issue(POKE, 16'hEE); resp_is("R7", 1, 1, 0); flags_are("R7", DEPTH);
    issue(GET_B, 16'h0); resp_is("R7", 1, 1, 16'hEE);
    for (int i = 1; i < DEPTH; i++) begin
      issue(GET_B, 16'h0); resp_is("R7", 1, 1, 16'hE0 + i);
    end
  endtask

  task automatic t_block_put;
    for (int i = 0; i < DEPTH; i++) issue(PUT_B, 16'hF0 + 16'(i));
    issue(PUT_B, 16'hF9); resp_is("R8", 0, 0, 0); chk("R8", "busy", busy_o, 1);
    flags_are("R8", DEPTH);
    issue(PEEK_NB, 16'h0); resp_is("R10", 0, 0, 0); chk("R10", "busy", busy_o, 1);
    issue(GET_B, 16'h0); resp_is("R8", 1, 1, 16'hF0); chk("R8", "level", level_o, DEPTH - 1);
    @(negedge clk);
    resp_is("R8", 1, 1, 0); chk("R8", "busy", busy_o, 0); flags_are("R8", DEPTH);
    for (int i = 1; i < DEPTH; i++) begin
      issue(GET_B, 16'h0); resp_is("R8", 1, 1, 16'hF0 + i);
    end
    issue(GET_B, 16'h0); resp_is("R8", 1, 1, 16'hF9);
  endtask

  task automatic t_block_get_peek;
    issue(GET_B, 16'h0); resp_is("R9", 0, 0, 0); chk("R9", "busy", busy_o, 1);
    issue(POKE, 16'h11); resp_is("R10", 0, 0, 0); chk("R10", "level", level_o, 0);
    issue(PUT_B, 16'h55); resp_is("R9", 1, 1, 0);
    @(negedge clk);
    resp_is("R9", 1, 1, 16'h55); chk("R9", "busy", busy_o, 0); flags_are("R9", 0);
    issue(PEEK_B, 16'h0); resp_is("R9", 0, 0, 0); chk("R9", "busy", busy_o, 1);
    issue(PUT_NB, 16'h66); resp_is("R9", 1, 1, 0);
    @(negedge clk);
    resp_is("R9", 1, 1, 16'h66); chk("R9", "busy", busy_o, 0); flags_are("R9", 1);
    issue(GET_NB, 16'h0); resp_is("R9", 1, 1, 16'h66);
  endtask

  task automatic t_nop;
    issue(PUT_B, 16'h77);
    issue(NOP, 16'h0); resp_is("R10", 0, 0, 0); flags_are("R10", 1);
    issue(GET_B, 16'h0); resp_is("R10", 1, 1, 16'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_order_wrap();
    t_limits();
    t_peek();
    t_poke();
    t_block_put();
    t_block_get_peek();
    t_nop();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule